// File: doc/BRIEF.md
# Program Status Polling Read Multiplexer

This block sits on the read path of a flash array. It decides what a read returns while the array's internal program cycle is running. While the program controller reports busy, every read becomes a status poll. The returned byte then carries two progress indicators at once:

- bit 7 holds the inverse of bit 7 of the byte most recently loaded for programming;
- bit 6 flips on every read access.

Once busy drops, reads return the array contents unchanged, and bit 6 no longer moves.

Each read is a one-cycle pulse on `rd_strobe`. The byte chosen for that read is registered and appears on `rd_data` from the next clock cycle. It stays there until the next read.

The polling phase is tracked by a small state machine with three states:

- `PS_IDLE`: no program cycle is seen.
- `PS_EVEN`: busy; the next poll returns bit 6 = 0.
- `PS_ODD`: busy; the next poll returns bit 6 = 1.

The transitions are:

- Any state goes to `PS_IDLE` when busy is low.
- `PS_IDLE` goes to `PS_EVEN` when busy rises without a read. It goes straight to `PS_ODD` when busy rises with a read in the same cycle, because that read is already a poll.
- `PS_EVEN` goes to `PS_ODD` on a read.
- `PS_ODD` goes to `PS_EVEN` on a read.
- Without a read, `PS_EVEN` and `PS_ODD` hold their state.

Top module: `poll_status_mux`

## Requirements
- R1: After reset `rd_data` is 0x00, and the first poll of the next program cycle returns bit 6 = 0.
- R2: A read with `busy` low returns `array_data`, as sampled at the strobe, on `rd_data` one cycle later.
- R3: A read with `busy` high returns the inverse of `last_byte[7]` on `rd_data[7]`.
- R4: A read with `busy` high returns `last_byte[5:0]` unchanged on `rd_data[5:0]`.
- R5: Within one program cycle the first poll returns bit 6 = 0, and each later poll returns the inverse of the previous poll's bit 6. This includes a poll made in the very first cycle in which `busy` is high.
- R6: Without a read strobe, `rd_data` keeps its value and the bit 6 phase does not advance, however many clock cycles pass.
- R7: When `busy` goes low the phase is cleared, so the first poll of a following program cycle again returns bit 6 = 0.
- R8: While `busy` is high, `array_data` has no effect on `rd_data`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_strobe | input | 1 | One-cycle pulse per read access |
| busy | input | 1 | High while the internal program cycle runs |
| last_byte | input | 8 | Data of the most recent byte load, including a rejected protected write |
| array_data | input | 8 | Array contents at the read address |
| rd_data | output | 8 | Registered read result |

## Verification
On every cycle, the assertions check four things:

- the pass-through of array data while idle;
- the inverted bit 7 and the copied low bits while busy;
- the alternation of bit 6 against a parity tracked in the checker;
- that `rd_data` holds between reads.

Only the bench's scenarios show the rest:

- the reset value;
- the restart of the bit 6 phase across back-to-back program cycles;
- a poll in the first busy cycle;
- that array data changing during busy leaves the output untouched.

// File: rtl/poll_pkg.sv
package poll_pkg;
    typedef enum logic [1:0] {
        PS_IDLE = 2'd0,
        PS_EVEN = 2'd1,
        PS_ODD  = 2'd2
    } poll_state_e;
endpackage

// File: rtl/poll_fsm.sv
module poll_fsm
    import poll_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        busy,
    input  logic        rd_strobe,
    output poll_state_e state_q,
    output logic        phase_o
);
    poll_state_e state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PS_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (!busy) begin
            state_d = PS_IDLE;
        end else begin
            unique case (state_q)
                PS_IDLE, PS_EVEN: state_d = rd_strobe ? PS_ODD  : PS_EVEN;
                PS_ODD:           state_d = rd_strobe ? PS_EVEN : PS_ODD;
                default:          state_d = PS_IDLE;
            endcase
        end
    end

    // bit 6 value a poll in this cycle reports (IDLE counts as even)
    always_comb begin
        unique case (state_q)
            PS_ODD:  phase_o = 1'b1;
            default: phase_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/poll_status_fmt.sv
module poll_status_fmt #(
    parameter int DATA_W     = 8,
    parameter int POLL_BIT   = 7,
    parameter int TOGGLE_BIT = 6
) (
    input  logic [DATA_W-1:0] last_byte,
    input  logic              phase,
    output logic [DATA_W-1:0] status
);
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        if (i == POLL_BIT) begin : g_poll
            assign status[i] = ~last_byte[i];
        end else if (i == TOGGLE_BIT) begin : g_tog
            assign status[i] = phase;
        end else begin : g_copy
            assign status[i] = last_byte[i];
        end
    end
endmodule

// File: rtl/poll_rd_reg.sv
module poll_rd_reg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_strobe,
    input  logic              busy,
    input  logic [DATA_W-1:0] status,
    input  logic [DATA_W-1:0] array_data,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] sel_data;

    always_comb sel_data = busy ? status : array_data;

    // output register: updates only on a read access
    always_ff @(posedge clk) begin
        if (!rst_n)         rd_data <= '0;
        else if (rd_strobe) rd_data <= sel_data;
    end
endmodule

// File: rtl/poll_status_mux.sv
module poll_status_mux
    import poll_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int POLL_BIT   = 7,
    parameter int TOGGLE_BIT = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_strobe,
    input  logic              busy,
    input  logic [DATA_W-1:0] last_byte,
    input  logic [DATA_W-1:0] array_data,
    output logic [DATA_W-1:0] rd_data
);
    poll_state_e       state_q;
    logic              phase;
    logic [DATA_W-1:0] status;

    poll_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .busy      (busy),
        .rd_strobe (rd_strobe),
        .state_q   (state_q),
        .phase_o   (phase)
    );

    poll_status_fmt #(
        .DATA_W     (DATA_W),
        .POLL_BIT   (POLL_BIT),
        .TOGGLE_BIT (TOGGLE_BIT)
    ) u_fmt (
        .last_byte (last_byte),
        .phase     (phase),
        .status    (status)
    );

    poll_rd_reg #(.DATA_W(DATA_W)) u_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_strobe  (rd_strobe),
        .busy       (busy),
        .status     (status),
        .array_data (array_data),
        .rd_data    (rd_data)
    );
endmodule

// File: rtl/poll_status_mux_chk.sv
module poll_status_mux_chk #(
    parameter int DATA_W     = 8,
    parameter int POLL_BIT   = 7,
    parameter int TOGGLE_BIT = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_strobe,
    input logic              busy,
    input logic [DATA_W-1:0] last_byte,
    input logic [DATA_W-1:0] array_data,
    input logic [DATA_W-1:0] rd_data
);
    // parity of polls seen in the current program cycle
    logic par;
    always_ff @(posedge clk) begin
        if (!rst_n || !busy) par <= 1'b0;
        else if (rd_strobe)  par <= ~par;
    end

    a_r2_idle_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && !busy) |=> rd_data == $past(array_data));

    a_r3_poll_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && busy) |=> rd_data[POLL_BIT] == !$past(last_byte[POLL_BIT]));

    a_r4_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && busy) |=> rd_data[5:0] == $past(last_byte[5:0]));

    a_r5_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && busy) |=> rd_data[TOGGLE_BIT] == $past(par));

    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_strobe |=> $stable(rd_data));
endmodule

bind poll_status_mux poll_status_mux_chk #(
    .DATA_W     (DATA_W),
    .POLL_BIT   (POLL_BIT),
    .TOGGLE_BIT (TOGGLE_BIT)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_strobe  (rd_strobe),
    .busy       (busy),
    .last_byte  (last_byte),
    .array_data (array_data),
    .rd_data    (rd_data)
);

// File: tb/tb_poll_status_mux.sv
module tb_poll_status_mux;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rd_strobe = 1'b0;
    logic       busy = 1'b0;
    logic [7:0] last_byte = '0;
    logic [7:0] array_data = '0;
    logic [7:0] rd_data;

    int   n_chk = 0;
    int   n_bad = 0;
    bit   done = 1'b0;
    bit   btog = 1'b0;
    logic [7:0] exp_q = '0;

    always #5 clk = ~clk;

    poll_status_mux dut (
        .clk(clk), .rst_n(rst_n), .rd_strobe(rd_strobe), .busy(busy),
        .last_byte(last_byte), .array_data(array_data), .rd_data(rd_data)
    );

    function automatic logic [7:0] status_of(logic [7:0] l, bit t);
        return {~l[7], t, l[5:0]};
    endfunction

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one clock cycle; inputs set just after a falling edge, output sampled at the next
    task automatic step(bit rd, bit b, logic [7:0] l, logic [7:0] a, string req);
        rd_strobe = rd; busy = b; last_byte = l; array_data = a;
        if (rd) exp_q = b ? status_of(l, btog) : a;
        if (!b) btog = 1'b0;
        else if (rd) btog = ~btog;
        @(negedge clk);
        chk(req, rd_data, exp_q);
    endtask

    initial begin
        void'($urandom(32'd4321));
        repeat (3) @(negedge clk);
        chk("R1 reset value", rd_data, 8'h00);
        rst_n = 1'b1;
        step(0, 0, 8'h00, 8'h00, "R6 idle hold");
        step(1, 0, 8'h11, 8'hA5, "R2 idle read");
        step(1, 0, 8'h11, 8'h3C, "R2 idle read 2");
        // poll in the very first busy cycle: bit6=0, bit7=~1=0, low bits 0x15
        step(1, 1, 8'h95, 8'hFF, "R5 R1 first poll");
        chk("R3 bit7 inverted", {7'd0, rd_data[7]}, 8'h00);
        chk("R4 low bits", {2'd0, rd_data[5:0]}, 8'h15);
        step(1, 1, 8'h95, 8'h00, "R5 second poll toggles");
        chk("R5 bit6 set", {7'd0, rd_data[6]}, 8'h01);
        step(0, 1, 8'h95, 8'h77, "R6 hold busy");
        step(0, 1, 8'h95, 8'h12, "R6 hold busy 2");
        step(1, 1, 8'h95, 8'h99, "R6 R8 phase held, array ignored");
        step(1, 1, 8'h2A, 8'h44, "R3 R4 new last byte");
        step(1, 0, 8'h2A, 8'h5E, "R7 true data after busy");
        step(1, 1, 8'hC0, 8'h01, "R7 phase restart");
        chk("R7 bit6 zero", {7'd0, rd_data[6]}, 8'h00);
        step(0, 0, 8'hC0, 8'h01, "R7 busy clear");
        step(0, 1, 8'hC0, 8'h01, "R7 busy no read");
        step(1, 1, 8'h40, 8'h02, "R7 restart after idle busy");
        // random traffic
        for (int i = 0; i < 400; i++) begin
            bit b = ($urandom % 5) != 0;
            bit r = ($urandom % 3) != 0;
            step(r, b, 8'($urandom), 8'($urandom),
                 b ? "R3 R4 R5 R8 random poll" : "R2 R6 random idle");
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule